// File: doc/BRIEF.md
# ADC Conversion Cycle Sequencer

This block is the control sequencer for a slow, self-timed analog-to-digital converter. It steps the converter through three operating phases: a timed conversion, a low-power wait, and a serial data transfer. The analog modulator and the decimation filter sit outside the block. The modulator is represented here only by a busy window of `CONV_CYC` system-clock cycles. At the end of that window the block pulses a capture strobe, so that the result is latched into an external holding register. The block then powers the converter down. Either the reference stays on (nap), or the reference is also switched off (sleep).

The sequencer waits in the powered-down phase until the serial bus logic reports that this device's read or write address was acknowledged. The reference is then switched back on and the transfer phase begins. When the bus side reports that the full result has been shifted out, or that a stop condition was seen, a new conversion starts at once. A sleep request is only heard during the transfer phase, and it sets the power-down mode that follows the next conversion. Once a conversion has started, it runs to completion. Only a supply dip or the system reset can cut it short. Either of these triggers an internal power-on hold of `POR_CYC` cycles that clears every register.

The block also tracks reference warm-up. A result is marked valid only if the reference had been on for at least `REF_CYC` cycles when the conversion began. For this reason, the first conversion after power-up is always flagged invalid. All durations are counted in system-clock cycles. No data path crosses this block, so every pin is a plain level or single-cycle control signal and none uses a valid/ready handshake.

Top module: `adc_cycle_seq`

## Requirements
- R1: While `rst_n` or `supply_ok` is low, and for the cycle after `supply_ok` is sampled low, all outputs are 0. After both are high, `conv_en` rises after exactly `POR_CYC` clock edges, counted from the first edge that samples `supply_ok` high.
- R2: Each conversion holds `conv_en` high for exactly `CONV_CYC` consecutive cycles. `capture_stb` is high for one cycle only, which is the last cycle of that window.
- R3: While converting, `addr_ack`, `stop_seen`, `read_done` and `sleep_req` have no effect: the conversion still lasts `CONV_CYC` cycles. Only a supply drop or `rst_n` ends it early.
- R4: After the capture cycle, the block is powered down: `conv_en`=0 and `xfer_active`=0. In nap mode `ref_en` stays 1.
- R5: If `sleep_req` is sampled high in any transfer cycle, the power-down after the next conversion is sleep (`ref_en`=0). A `sleep_req` outside the transfer phase is ignored. A request applies to one power-down only; the default is nap.
- R6: In power-down, the block stays put until `addr_ack` is sampled high. In the following cycle `xfer_active`=1 and `ref_en`=1.
- R7: In transfer, `read_done` or `stop_seen` sampled high gives `conv_en`=1 and `xfer_active`=0 in the next cycle. Otherwise the transfer phase continues.
- R8: `result_valid` is updated only at the end of a capture cycle. It becomes 1 exactly when `ref_en` was high in each of the `REF_CYC` cycles just before the conversion's first cycle. It holds between captures and is cleared by the power-on hold, so the first conversion after power-up gives 0.
- R9: `conv_en` high implies `ref_en` high and `xfer_active` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a power-on hold |
| supply_ok | input | 1 | High while the supply is above its threshold; low forces a power-on hold |
| addr_ack | input | 1 | Pulse: the device address of a read or write was acknowledged |
| stop_seen | input | 1 | Pulse: a stop condition was seen on the bus |
| read_done | input | 1 | Pulse: all result bits have been shifted out |
| sleep_req | input | 1 | Sleep selection, heard only during transfer |
| conv_en | output | 1 | Modulator power and busy window |
| ref_en | output | 1 | Reference power enable |
| xfer_active | output | 1 | Transfer phase in progress |
| capture_stb | output | 1 | One-cycle strobe to latch the conversion result |
| result_valid | output | 1 | Held result was taken with a settled reference |

## Verification
A wrong phase register shows up at the ports within one cycle. Examples are a conversion that ends early, a transfer that never ends, or `ref_en` dropping while `conv_en` is high, and all of these are visible as soon as the window length or the enable combination is wrong. A wrong sleep latch or warm-up counter stays hidden until the next power-down or capture. The bench therefore sweeps transfer lengths on both sides of the `REF_CYC` boundary and alternates nap and sleep, so that every capture reveals `result_valid` and every power-down reveals `ref_en`. Supply drops are injected during conversion and during transfer, to show that the hold length and the cleared validity take effect after a single edge.

// File: rtl/adc_cycle_seq_pkg.sv
package adc_cycle_seq_pkg;

  typedef enum logic [1:0] {
    PH_CONVERT   = 2'd0,
    PH_POWERDOWN = 2'd1,
    PH_TRANSFER  = 2'd2
  } phase_e;

  // Counter width able to hold the value n (at least one bit).
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/adc_cycle_seq_por.sv
// Power-on hold: stays active while the supply is low and for POR_CYC edges after it returns.
module adc_cycle_seq_por #(
  parameter int unsigned POR_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic por_active
);
  import adc_cycle_seq_pkg::*;
  localparam int unsigned W = cnt_w(POR_CYC);
  localparam logic [W-1:0] FULL = W'(POR_CYC);

  logic [W-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_cnt <= FULL;
    else if (!supply_ok)       hold_cnt <= FULL;
    else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
  end

  assign por_active = (hold_cnt != '0);
endmodule

// File: rtl/adc_cycle_seq_convtmr.sv
// Conversion busy timer: loaded on entry, counts down while running, flags the last cycle.
module adc_cycle_seq_convtmr #(
  parameter int unsigned CONV_CYC = 16600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic run,
  output logic last
);
  import adc_cycle_seq_pkg::*;
  localparam int unsigned W = cnt_w(CONV_CYC);
  localparam logic [W-1:0] TOP = (CONV_CYC == 0) ? '0 : W'(CONV_CYC - 1);

  logic [W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         busy_cnt <= TOP;
    else if (clr || load)               busy_cnt <= TOP;
    else if (run && busy_cnt != '0)     busy_cnt <= busy_cnt - 1'b1;
  end

  assign last = run && (busy_cnt == '0);
endmodule

// File: rtl/adc_cycle_seq_refmon.sv
// Reference warm-up monitor: counts consecutive enabled cycles, saturating at REF_CYC.
module adc_cycle_seq_refmon #(
  parameter int unsigned REF_CYC = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ref_on,
  output logic settled
);
  import adc_cycle_seq_pkg::*;
  localparam int unsigned W = cnt_w(REF_CYC);
  localparam logic [W-1:0] GOAL = W'(REF_CYC);

  logic [W-1:0] warm_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 warm_cnt <= '0;
    else if (clr || !ref_on)    warm_cnt <= '0;
    else if (warm_cnt != GOAL)  warm_cnt <= warm_cnt + 1'b1;
  end

  assign settled = (warm_cnt == GOAL);
endmodule

// File: rtl/adc_cycle_seq_fsm.sv
// Phase controller: convert -> power-down -> transfer -> convert.
module adc_cycle_seq_fsm
  import adc_cycle_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   por_active,
  input  logic   conv_last,
  input  logic   ref_settled,
  input  logic   addr_ack,
  input  logic   stop_seen,
  input  logic   read_done,
  input  logic   sleep_req,
  output phase_e phase,
  output logic   conv_restart,
  output logic   deep_pd,
  output logic   good_result
);
  logic sleep_armed;
  logic ref_tainted;
  logic xfer_exit;

  assign xfer_exit    = (phase == PH_TRANSFER) && (read_done || stop_seen);
  assign conv_restart = xfer_exit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_CONVERT;
      sleep_armed <= 1'b0;
      deep_pd     <= 1'b0;
      good_result <= 1'b0;
      ref_tainted <= 1'b0;
    end else if (por_active) begin
      phase       <= PH_CONVERT;
      sleep_armed <= 1'b0;
      deep_pd     <= 1'b0;
      good_result <= 1'b0;
      ref_tainted <= 1'b0;
    end else begin
      case (phase)
        PH_CONVERT: begin
          if (conv_last) begin
            phase       <= PH_POWERDOWN;
            deep_pd     <= sleep_armed;
            sleep_armed <= 1'b0;
            good_result <= !(ref_tainted || !ref_settled);
          end else begin
            ref_tainted <= ref_tainted || !ref_settled;
          end
        end
        PH_POWERDOWN: begin
          if (addr_ack) begin
            phase   <= PH_TRANSFER;
            deep_pd <= 1'b0;
          end
        end
        PH_TRANSFER: begin
          if (sleep_req) sleep_armed <= 1'b1;
          if (xfer_exit) begin
            phase       <= PH_CONVERT;
            ref_tainted <= 1'b0;
          end
        end
        default: phase <= PH_CONVERT;
      endcase
    end
  end
endmodule

// File: rtl/adc_cycle_seq.sv
module adc_cycle_seq
  import adc_cycle_seq_pkg::*;
#(
  parameter int unsigned POR_CYC  = 500,
  parameter int unsigned CONV_CYC = 16600,
  parameter int unsigned REF_CYC  = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic addr_ack,
  input  logic stop_seen,
  input  logic read_done,
  input  logic sleep_req,
  output logic conv_en,
  output logic ref_en,
  output logic xfer_active,
  output logic capture_stb,
  output logic result_valid
);
  logic   por_active;
  logic   conv_last;
  logic   conv_run;
  logic   conv_restart;
  logic   ref_settled;
  logic   deep_pd;
  logic   good_result;
  phase_e phase;

  adc_cycle_seq_por #(.POR_CYC(POR_CYC)) u_por (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .por_active(por_active)
  );

  assign conv_run = !por_active && (phase == PH_CONVERT);

  adc_cycle_seq_convtmr #(.CONV_CYC(CONV_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(por_active), .load(conv_restart),
    .run(conv_run), .last(conv_last)
  );

  adc_cycle_seq_refmon #(.REF_CYC(REF_CYC)) u_ref (
    .clk(clk), .rst_n(rst_n), .clr(por_active), .ref_on(ref_en),
    .settled(ref_settled)
  );

  adc_cycle_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .por_active(por_active), .conv_last(conv_last),
    .ref_settled(ref_settled), .addr_ack(addr_ack), .stop_seen(stop_seen),
    .read_done(read_done), .sleep_req(sleep_req), .phase(phase),
    .conv_restart(conv_restart), .deep_pd(deep_pd), .good_result(good_result)
  );

  assign conv_en      = conv_run;
  assign ref_en       = !por_active && !((phase == PH_POWERDOWN) && deep_pd);
  assign xfer_active  = !por_active && (phase == PH_TRANSFER);
  assign capture_stb  = conv_last;
  assign result_valid = !por_active && good_result;
endmodule

// File: rtl/adc_cycle_seq_chk.sv
module adc_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic stop_seen,
  input logic read_done,
  input logic conv_en,
  input logic ref_en,
  input logic xfer_active,
  input logic capture_stb,
  input logic result_valid
);
  AST_SUPPLY_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!conv_en && !ref_en && !xfer_active && !capture_stb && !result_valid)); // R1

  AST_CAPTURE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    capture_stb |-> conv_en); // R2

  AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_stb |=> !capture_stb); // R2

  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && !capture_stb && supply_ok) |=> conv_en); // R3

  AST_POWERDOWN_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_stb && supply_ok) |=> (!conv_en && !xfer_active)); // R4

  AST_XFER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && supply_ok && (read_done || stop_seen)) |=> (conv_en && !xfer_active)); // R7

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && supply_ok && !read_done && !stop_seen) |=> xfer_active); // R7

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_stb && supply_ok) |=> $stable(result_valid)); // R8

  AST_CONV_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en |-> (ref_en && !xfer_active)); // R9
endmodule

bind adc_cycle_seq adc_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .stop_seen(stop_seen),
  .read_done(read_done), .conv_en(conv_en), .ref_en(ref_en),
  .xfer_active(xfer_active), .capture_stb(capture_stb), .result_valid(result_valid)
);

// File: tb/adc_cycle_seq_tb.sv
`timescale 1ns/1ps
module adc_cycle_seq_tb;
  localparam int POR  = 5;
  localparam int CONV = 12;
  localparam int REFW = 20;

  logic clk = 1'b0;
  logic rst_n, supply_ok, addr_ack, stop_seen, read_done, sleep_req;
  logic conv_en, ref_en, xfer_active, capture_stb, result_valid;

  int checks = 0;
  int errors = 0;
  int r9_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_cycle_seq #(.POR_CYC(POR), .CONV_CYC(CONV), .REF_CYC(REFW)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .addr_ack(addr_ack),
    .stop_seen(stop_seen), .read_done(read_done), .sleep_req(sleep_req),
    .conv_en(conv_en), .ref_en(ref_en), .xfer_active(xfer_active),
    .capture_stb(capture_stb), .result_valid(result_valid)
  );

  // R9 monitor on sampled ports
  always @(negedge clk)
    if (conv_en && (!ref_en || xfer_active)) r9_bad++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic all_off(input string req);
    chk(req, {conv_en, ref_en, xfer_active, capture_stb, result_valid}, 0);
  endtask

  task automatic clear_inputs();
    addr_ack = 0; stop_seen = 0; read_done = 0; sleep_req = 0;
  endtask

  // Called at a negedge with supply just raised; counts edges to conv_en.
  task automatic por_wait();
    int n = 0;
    while (!conv_en) begin
      @(negedge clk);
      n++;
    end
    chk("R1 por length", n, POR);
  endtask

  // Called at a negedge in the first conversion cycle.
  task automatic measure_conv(input bit noise, input bit exp_valid, input bit exp_sleep);
    int len = 0, caps = 0, cap_at = 0;
    while (conv_en) begin
      len++;
      if (capture_stb) begin caps++; cap_at = len; end
      if (noise) begin
        addr_ack = len[0]; stop_seen = !len[0]; read_done = len[1]; sleep_req = 1;
      end
      @(negedge clk);
    end
    clear_inputs();
    chk(noise ? "R3 conv length under noise" : "R2 conv length", len, CONV);
    chk("R2 capture count", caps, 1);
    chk("R2 capture position", cap_at, CONV);
    chk("R8 result_valid", result_valid, exp_valid);
    chk("R4 xfer after capture", xfer_active, 0);
    chk(exp_sleep ? "R5 sleep ref off" : "R4 nap ref on", ref_en, !exp_sleep);
  endtask

  // Power-down idle with ignored stimulus.
  task automatic idle(input int k, input bit exp_sleep);
    sleep_req = 1; stop_seen = 1; read_done = 1;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      clear_inputs();
      chk("R6 stays powered down", {conv_en, xfer_active}, 0);
      chk("R5 pd ref state", ref_en, !exp_sleep);
    end
  endtask

  task automatic wake_and_xfer(input int n, input bit req_sleep, input bit by_stop);
    addr_ack = 1;
    @(negedge clk);
    addr_ack = 0;
    chk("R6 wake xfer", xfer_active, 1);
    chk("R6 wake ref", ref_en, 1);
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      chk("R7 xfer holds", xfer_active, 1);
    end
    sleep_req = req_sleep;
    if (by_stop) stop_seen = 1; else read_done = 1;
    @(negedge clk);
    clear_inputs();
    chk(by_stop ? "R7 stop restarts" : "R7 read_done restarts", conv_en, 1);
    chk("R7 xfer ends", xfer_active, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens[4] = '{1, 19, 20, 25};
    bit prev_sleep;
    rst_n = 0; supply_ok = 0;
    clear_inputs();
    repeat (3) @(negedge clk);
    all_off("R1 in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    all_off("R1 supply low");
    supply_ok = 1;
    por_wait();
    measure_conv(1'b1, 1'b0, 1'b0);   // R8 first result invalid, R3 noise, R5 ignored
    idle(25, 1'b0);
    prev_sleep = 1'b0;
    for (int k = 0; k < 16; k++) begin
      bit s = k[0];
      int n = lens[k[2:1]];
      bit e = k[3];
      bit ev;
      idle(8, prev_sleep);
      wake_and_xfer(n, s, e);
      ev = prev_sleep ? (n >= REFW) : 1'b1;
      measure_conv(1'b0, ev, s);
      prev_sleep = s;
    end
    // Supply drop during a conversion
    idle(25, prev_sleep);
    wake_and_xfer(2, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    supply_ok = 0;
    @(negedge clk);
    all_off("R1 drop mid conversion");
    supply_ok = 1;
    por_wait();
    measure_conv(1'b0, 1'b0, 1'b0);   // R8 cleared by hold
    // Supply drop during transfer
    idle(25, 1'b0);
    addr_ack = 1;
    @(negedge clk);
    addr_ack = 0;
    supply_ok = 0;
    @(negedge clk);
    all_off("R1 drop mid transfer");
    supply_ok = 1;
    por_wait();
    measure_conv(1'b0, 1'b0, 1'b0);
    chk("R9 conv implies ref and no xfer", r9_bad, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule